// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from a transmit queue, shifts them out on MOSI while driving SCLK, and assembles the bits it samples from MISO into words that it hands to a receive queue. The queue storage, the chip selects, the register bus and interrupt routing all live outside this block. The engine sees the queues only through a valid/pop pair on the transmit side and a push strobe on the receive side.

Software-visible settings arrive as parallel inputs and are captured only while the enable input is low. They cover word length, bit-rate divider, clock polarity, a phase bit, a separate idle level for SCLK, bit order, internal loopback, and independent off switches for the transmitter and receiver. Once enabled, the engine starts a word whenever the transmit queue has data and the transmitter is on. It chains words with no idle time between them. It reports activity on a busy output.

Top module: `spi_shift_engine`

## Requirements
- R1: The word length is the length field plus one (field 5'd7 = 8 bits, 5'd15 = 16, 5'd23 = 24, 5'd31 = 32, 5'd1 = 2). Exactly that many bits are shifted per word, on MOSI and from MISO.
- R2: Each SCLK half-level lasts div+1 module clocks, so one bit takes 2*(div+1) clocks. Divider value 0 gives half the module clock rate.
- R3: While shifting, the phase bit set to 1 makes the first half of every bit sit at the polarity level. The phase bit cleared to 0 makes the first half sit at the inverted polarity level. MOSI changes only at bit boundaries, and MISO is sampled at the mid-bit transition, which goes into level polarity XOR phase.
- R4: Whenever no word is being shifted (including during and right after reset), SCLK equals the captured idle-level bit and MOSI is 0.
- R5: With the order bit at 1, the most significant bit (bit n-1) goes first. With it at 0, bit 0 goes first. The same order applies when receiving. Received words come out right-aligned, with all bits above n-1 at zero.
- R6: With loopback set, the receiver takes the bit currently on MOSI and ignores MISO.
- R7: With the transmit-off bit set, no word starts and tx_pop_o stays low, even if tx_valid_i is high.
- R8: With the receive-off bit set, rx_push_o never pulses, while MOSI still carries the words.
- R9: busy_o is high from the clock after a word starts until the last bit of the last chained word ends, and is low otherwise.
- R10: A word starts only when enabled, the transmitter is on and tx_valid_i is high. tx_pop_o pulses in that same cycle. A following word is popped exactly 2*n*(div+1) clocks after the previous one, with no gap.
- R11: Configuration inputs are captured only while en_i is low. Changes made while enabled do not affect the word in flight.
- R12: Dropping en_i mid-word aborts it. busy_o falls on the next clock edge and that word is never pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Engine enable; low = configuration capture |
| cfg_wlen_i | input | 5 | Bits per word minus one |
| cfg_div_i | input | 16 | Bit-rate divider value |
| cfg_pol_i | input | 1 | Clock polarity |
| cfg_phs_i | input | 1 | Phase bit (1 = sample on first transition) |
| cfg_idle_i | input | 1 | SCLK level between words |
| cfg_msb_i | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_loop_i | input | 1 | Internal loopback of MOSI into receiver |
| cfg_txoff_i | input | 1 | Transmitter off |
| cfg_rxoff_i | input | 1 | Receiver off |
| tx_data_i | input | 32 | Head word of transmit queue |
| tx_valid_i | input | 1 | Transmit queue not empty |
| tx_pop_o | output | 1 | Takes the head word this cycle |
| rx_data_o | output | 32 | Received word, right-aligned |
| rx_push_o | output | 1 | One-cycle strobe: rx_data_o valid |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Word shifting in progress |

## Verification
The bench builds the engine with its default parameters: a 32-bit data path and a 16-bit divider. With these defaults the full word-length set can be reached, including the 24-bit and 32-bit words and the bit-31 alignment edge of LSB-first reception. Divider values 0 to 3 are programmed at run time, so every SPI mode and both bit orders finish in a few hundred clocks. The bench's own slave model drives MISO from the mode rules, which lets it check both the phase inversion and the exact pop spacing of chained words.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Settings captured while the engine is disabled.
  typedef struct packed {
    logic pol;     // clock polarity
    logic phs;     // phase bit, 1 = sample on first transition of a bit
    logic idle;    // SCLK level between words
    logic msb;     // bit order, 1 = most significant first
    logic loop;    // MOSI fed back into receiver
    logic tx_off;  // transmitter switched off
    logic rx_off;  // receiver switched off
  } mode_t;

  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    tick_o = run_i && (cnt_q == div_i);
    cnt_en = run_i || (cnt_q != '0);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: a half-bit never runs past the divider value
  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i));

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_eng_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tx_ok_i,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic             tick_i,
  output logic             busy_o,
  output half_e            half_o,
  output logic             load_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             last_o
);

  logic             busy_q, busy_d;
  half_e            half_q, half_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d   = busy_q;
    half_d   = half_q;
    cnt_d    = cnt_q;
    load_o   = 1'b0;
    sample_o = 1'b0;
    shift_o  = 1'b0;
    last_o   = 1'b0;
    if (!en_i) begin
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (tx_ok_i) begin
        load_o = 1'b1;
        busy_d = 1'b1;
        half_d = HALF_LEAD;
        cnt_d  = '0;
      end
    end else if (tick_i) begin
      if (half_q == HALF_LEAD) begin
        sample_o = 1'b1;
        last_o   = (cnt_q == wlen_i);
        half_d   = HALF_TRAIL;
      end else if (cnt_q == wlen_i) begin
        if (tx_ok_i) begin
          load_o = 1'b1;
          half_d = HALF_LEAD;
          cnt_d  = '0;
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        shift_o = 1'b1;
        half_d  = HALF_LEAD;
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= HALF_LEAD;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign half_o = half_q;

  // R1: bit index stays within the programmed word
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= wlen_i));

  // R12: a cycle with enable low leaves the engine idle
  a_r12_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !busy_q);

  // R10: a new word is never taken while the previous one is mid-way
  a_r10_load_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && busy_q) |-> (half_q == HALF_TRAIL && cnt_q == wlen_i));

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic [LEN_W-1:0]  wlen_i,
  input  logic              msb_i,
  input  logic              loop_i,
  input  logic              rx_en_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o
);

  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d, rx_nxt;
  logic [DATA_W-1:0] word_q, word_d;
  logic              push_d, push_q;
  logic              tx_bit, rx_bit;
  logic              tx_en, rx_en, word_en;

  always_comb begin
    tx_bit = msb_i ? tx_q[wlen_i] : tx_q[0];
    rx_bit = loop_i ? tx_bit : miso_i;
    rx_nxt = msb_i ? {rx_q[DATA_W-2:0], rx_bit} : {rx_bit, rx_q[DATA_W-1:1]};

    tx_en = load_i || shift_i;
    if (load_i)     tx_d = load_data_i;
    else if (msb_i) tx_d = tx_q << 1;
    else            tx_d = tx_q >> 1;

    rx_en = load_i || sample_i;
    rx_d  = load_i ? '0 : rx_nxt;

    word_en = sample_i && last_i && rx_en_i;
    word_d  = msb_i ? rx_nxt : (rx_nxt >> (TOP_IDX - wlen_i));
    push_d  = word_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      word_q <= '0;
      push_q <= 1'b0;
    end else begin
      if (tx_en)   tx_q   <= tx_d;
      if (rx_en)   rx_q   <= rx_d;
      if (word_en) word_q <= word_d;
      push_q <= push_d;
    end
  end

  assign mosi_o    = busy_i & tx_bit;
  assign rx_data_o = word_q;
  assign rx_push_o = push_q;

  // R5: a delivered word carries nothing above its top bit
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> ((DATA_W + LEN_W)'(rx_data_o) >> ({1'b0, wlen_i} + 1'b1)) == '0);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  cfg_wlen_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              cfg_pol_i,
  input  logic              cfg_phs_i,
  input  logic              cfg_idle_i,
  input  logic              cfg_msb_i,
  input  logic              cfg_loop_i,
  input  logic              cfg_txoff_i,
  input  logic              cfg_rxoff_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_pop_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o
);

  localparam logic [LEN_W-1:0] WLEN_RST = LEN_W'(7);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // configuration capture while disabled
  mode_t            mode_q, mode_d;
  logic [LEN_W-1:0] wlen_q;
  logic [DIV_W-1:0] div_q;
  logic             cfg_en;

  always_comb begin
    cfg_en        = !en_i;
    mode_d.pol    = cfg_pol_i;
    mode_d.phs    = cfg_phs_i;
    mode_d.idle   = cfg_idle_i;
    mode_d.msb    = cfg_msb_i;
    mode_d.loop   = cfg_loop_i;
    mode_d.tx_off = cfg_txoff_i;
    mode_d.rx_off = cfg_rxoff_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      wlen_q <= WLEN_RST;
      div_q  <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      wlen_q <= cfg_wlen_i;
      div_q  <= cfg_div_i;
    end
  end

  logic  tick, load, sample, shift, last, tx_ok, busy;
  half_e half;

  assign tx_ok = tx_valid_i && !mode_q.tx_off;

  spi_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (busy),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_seq_ctrl #(.LEN_W(LEN_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en_i),
    .tx_ok_i  (tx_ok),
    .wlen_i   (wlen_q),
    .tick_i   (tick),
    .busy_o   (busy),
    .half_o   (half),
    .load_o   (load),
    .sample_o (sample),
    .shift_o  (shift),
    .last_o   (last)
  );

  spi_bit_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .busy_i      (busy),
    .load_i      (load),
    .load_data_i (tx_data_i),
    .shift_i     (shift),
    .sample_i    (sample),
    .last_i      (last),
    .wlen_i      (wlen_q),
    .msb_i       (mode_q.msb),
    .loop_i      (mode_q.loop),
    .rx_en_i     (!mode_q.rx_off),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_data_o   (rx_data_o),
    .rx_push_o   (rx_push_o)
  );

  // leading-half level: polarity when phase bit set, inverted otherwise
  logic lead_lvl;
  always_comb begin
    lead_lvl = mode_q.pol ^ !mode_q.phs;
    if (!busy)                  sclk_o = mode_q.idle;
    else if (half == HALF_LEAD) sclk_o = lead_lvl;
    else                        sclk_o = !lead_lvl;
  end

  assign tx_pop_o = load;
  assign busy_o   = busy;

  // R11: settings never move in a cycle following an enabled cycle
  a_r11_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(en_i) |-> ($stable(mode_q) && $stable(wlen_q) && $stable(div_q)));

  // R7: nothing is taken from the queue with the transmitter off
  a_r7_no_pop_txoff: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_q.tx_off |-> !tx_pop_o);

  // R8: nothing is delivered with the receiver off
  a_r8_no_push_rxoff: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_q.rx_off |-> !rx_push_o);

  // R10: popping requires a non-empty queue and an enabled engine
  a_r10_pop_valid: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_pop_o |-> (tx_valid_i && en_i));

endmodule

// File: tb/test_spi_shift_engine.sv
`timescale 1ns/1ps
module test_spi_shift_engine;

  logic        clk, rst_n, en;
  logic [4:0]  wlen;
  logic [15:0] div;
  logic        pol, phs, idle, msb, loop, txoff, rxoff;
  logic [31:0] tx_data;
  logic        tx_valid, tx_pop;
  logic [31:0] rx_data;
  logic        rx_push, sclk, mosi, miso, busy;

  spi_shift_engine i_spi_shift_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .cfg_wlen_i(wlen), .cfg_div_i(div), .cfg_pol_i(pol), .cfg_phs_i(phs),
    .cfg_idle_i(idle), .cfg_msb_i(msb), .cfg_loop_i(loop),
    .cfg_txoff_i(txoff), .cfg_rxoff_i(rxoff),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_pop_o(tx_pop),
    .rx_data_o(rx_data), .rx_push_o(rx_push),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transmit queue model
  logic [31:0] fifo [8];
  int f_head = 0, f_tail = 0;
  assign tx_valid = (f_head != f_tail);
  assign tx_data  = fifo[f_head % 8];

  // monitors, cleared on request
  logic mon_clr = 1'b0;
  longint cyc = 0;
  longint pop_t [4];
  int npop = 0, nrx = 0, bsy_cnt = 0;
  logic [31:0] rx_got [4];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_pop) f_head <= f_head + 1;
    if (mon_clr) begin
      npop <= 0; nrx <= 0; bsy_cnt <= 0;
    end else begin
      if (tx_pop) begin pop_t[npop % 4] <= cyc; npop <= npop + 1; end
      if (rx_push) begin rx_got[nrx % 4] <= rx_data; nrx <= nrx + 1; end
      if (busy) bsy_cnt <= bsy_cnt + 1;
    end
  end

  // slave model: mode rules taken from the requirements
  int          cur_n = 8;
  logic        cur_msb = 1'b1, cur_pol = 1'b0, cur_phs = 1'b1;
  logic [31:0] cur_mw = '0;
  logic [127:0] cap;
  int capn = 0, sidx = 0;
  logic prev_sclk = 1'b0;

  function automatic logic bit_of(input logic [31:0] w, input int k, input int n, input logic m);
    return m ? w[n-1-k] : w[k];
  endfunction

  always @(negedge clk) begin
    if (mon_clr) capn = 0;
    if (!busy) begin
      miso = bit_of(cur_mw, 0, cur_n, cur_msb);
      sidx = cur_phs ? 1 : 0;
    end else if (sclk != prev_sclk) begin
      if (sclk == (cur_pol ^ cur_phs)) begin
        cap[capn % 128] = mosi;
        capn++;
      end else begin
        miso = bit_of(cur_mw, sidx % cur_n, cur_n, cur_msb);
        sidx++;
      end
    end
    prev_sclk = sclk;
  end

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic logic [31:0] cap_word(input int k);
    logic [31:0] w = '0;
    for (int i = 0; i < cur_n; i++)
      w[cur_msb ? (cur_n-1-i) : i] = cap[k*cur_n + i];
    return w;
  endfunction

  task automatic clr_mon();
    @(negedge clk) mon_clr = 1'b1;
    repeat (2) @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic setup(input int n, input logic m, input logic p, input logic h,
                       input logic lb, input int dv, input logic [31:0] mw);
    @(negedge clk);
    en = 1'b0; wlen = 5'(n-1); div = 16'(dv);
    pol = p; phs = h; idle = p; msb = m; loop = lb;
    cur_n = n; cur_msb = m; cur_pol = p; cur_phs = h; cur_mw = mw;
  endtask

  task automatic push_word(input logic [31:0] w);
    fifo[f_tail % 8] = w;
    f_tail = f_tail + 1;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (!busy && t < 200) begin @(negedge clk); t++; end
    while (busy && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk(1'b0, "R9 busy stuck", busy, 0);
  endtask

  typedef struct packed {
    logic [5:0]  n;
    logic        m, p, h, lb;
    logic [3:0]  dv;
    logic [31:0] tw, mw;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{6'd8,  1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 32'h0000_00A5, 32'h0000_003C},
    '{6'd8,  1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0000_0096, 32'h0000_00E1},
    '{6'd16, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 32'h0000_BEEF, 32'h0000_1234},
    '{6'd24, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 32'h00C0_FFEE, 32'h005A_5A01},
    '{6'd32, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 32'hDEAD_BEEF, 32'h0000_0000},
    '{6'd2,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 32'h0000_0002, 32'h0000_0001},
    '{6'd32, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 32'h8000_0001, 32'h7F00_FF02}
  };

  initial begin
    rst_n = 1'b0; en = 1'b0; wlen = 5'd7; div = '0;
    pol = 0; phs = 1; idle = 0; msb = 1; loop = 0; txoff = 0; rxoff = 0;
    miso = 1'b0;
    repeat (3) @(negedge clk);
    // R4 R9: reset state
    chk(busy == 1'b0, "R9 busy in reset", busy, 0);
    chk(sclk == 1'b0, "R4 sclk in reset", sclk, 0);
    chk(mosi == 1'b0, "R4 mosi in reset", mosi, 0);
    chk(tx_pop == 1'b0 && rx_push == 1'b0, "R10 strobes in reset", {tx_pop, rx_push}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: idle level follows its own bit, not polarity
    idle = 1'b1; pol = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R4 idle high", sclk, 1);
    idle = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R4 idle low", sclk, 0);

    // table: R1 R2 R3 R5 R6 R9 R10, two chained words each
    for (int v = 0; v < NV; v++) begin
      int n; int dv; logic [31:0] w0, w1, e0, e1;
      n = int'(VECS[v].n); dv = int'(VECS[v].dv);
      setup(n, VECS[v].m, VECS[v].p, VECS[v].h, VECS[v].lb, dv, VECS[v].mw);
      w0 = VECS[v].tw & msk(n);
      w1 = ~VECS[v].tw & msk(n);
      push_word(w0); push_word(w1);
      clr_mon();
      en = 1'b1;
      wait_idle();
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk(capn == 2*n, "R1 bit count", capn, 2*n);
      chk(cap_word(0) == w0, "R5 R3 mosi word0", cap_word(0), w0);
      chk(cap_word(1) == w1, "R5 R3 mosi word1", cap_word(1), w1);
      e0 = VECS[v].lb ? w0 : (VECS[v].mw & msk(n));
      e1 = VECS[v].lb ? w1 : (VECS[v].mw & msk(n));
      chk(nrx == 2, "R1 rx count", nrx, 2);
      chk(rx_got[0] == e0, "R5 R6 rx word0", rx_got[0], e0);
      chk(rx_got[1] == e1, "R5 R6 rx word1", rx_got[1], e1);
      chk(npop == 2 && (pop_t[1] - pop_t[0]) == longint'(2*n*(dv+1)),
          "R10 R2 pop spacing", pop_t[1] - pop_t[0], 2*n*(dv+1));
      chk(bsy_cnt == 4*n*(dv+1), "R9 R2 busy length", bsy_cnt, 4*n*(dv+1));
      chk(sclk == VECS[v].p, "R4 sclk idle after", sclk, VECS[v].p);
    end

    // R7: transmitter off blocks starts
    setup(8, 1'b1, 1'b0, 1'b1, 1'b0, 0, 32'h0);
    txoff = 1'b1;
    push_word(32'h5A);
    clr_mon();
    en = 1'b1;
    repeat (40) @(negedge clk);
    chk(npop == 0, "R7 no pop", npop, 0);
    chk(bsy_cnt == 0, "R7 no busy", bsy_cnt, 0);
    en = 1'b0; txoff = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    wait_idle();
    en = 1'b0;
    chk(npop == 1 && cap_word(0) == 32'h5A, "R7 resumes", cap_word(0), 32'h5A);

    // R8: receiver off, transmit continues
    setup(16, 1'b0, 1'b0, 1'b1, 1'b0, 0, 32'hFFFF);
    rxoff = 1'b1;
    push_word(32'h1234);
    clr_mon();
    en = 1'b1;
    wait_idle();
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(nrx == 0, "R8 no push", nrx, 0);
    chk(cap_word(0) == 32'h1234, "R8 mosi still", cap_word(0), 32'h1234);
    rxoff = 1'b0;

    // R11: changes while enabled are ignored
    setup(16, 1'b1, 1'b0, 1'b1, 1'b0, 1, 32'h00C3);
    push_word(32'hA00F);
    clr_mon();
    en = 1'b1;
    repeat (6) @(negedge clk);
    msb = 1'b0; wlen = 5'd7; pol = 1'b1; loop = 1'b1;
    wait_idle();
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(capn == 16, "R11 length held", capn, 16);
    chk(cap_word(0) == 32'hA00F, "R11 order held", cap_word(0), 32'hA00F);
    chk(nrx == 1 && rx_got[0] == 32'h00C3, "R11 loop held off", rx_got[0], 32'h00C3);

    // R12: abort mid-word
    setup(16, 1'b1, 1'b0, 1'b1, 1'b0, 3, 32'h0F0F);
    push_word(32'h8001);
    clr_mon();
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R12 running", busy, 1);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R12 busy drops", busy, 0);
    repeat (150) @(negedge clk);
    chk(nrx == 0, "R12 no push", nrx, 0);
    chk(sclk == 1'b0, "R12 sclk idle", sclk, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule